// File: doc/BRIEF.md
# Region to Aligned Page Splitter

This block turns a single memory-mapping request into the shortest greedy run of page descriptors that a page-table writer or TLB loader can consume one at a time. A request carries a virtual address, a physical address, a byte length and three attribute fields: element size, endianness and mixed-size mode. The block first widens the region so that it covers whole 4 KB pages. It then walks the region, and at each step it picks the largest of four page sizes (16 MB, 1 MB, 64 KB, 4 KB) that the remaining length can hold and to which the current virtual address is aligned.

Requests arrive on a valid/ready channel, and descriptors leave on a second one. A one-cycle `done` pulse closes every sequence. When no permitted page size fits, `cfg_err` pulses together with `done` and the sequence is abandoned. The set of permitted page sizes is a build parameter, `PAGE_MASK`, with bit i standing for page code i. With all four sizes enabled, normalisation guarantees that a 4 KB page always fits. The error path is therefore only reachable in a build that leaves out one or more sizes.

Top module: `page_splitter`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid`, `done` and `cfg_err` are 0 and `in_ready` is 1.
- R2: The region is widened before splitting. The low 12 bits of `in_va` are added to `in_size`, and the sum is rounded up to a multiple of 4096. The first descriptor carries `in_va` and `in_pa` with their low 12 bits cleared.
- R3: Each descriptor takes the largest enabled size that is no larger than the remaining length and to which the current virtual address is aligned. The `out_pgsz` code is 0 for 4 KB, 1 for 64 KB, 2 for 1 MB and 3 for 16 MB.
- R4: The alignment of the physical address plays no part in the choice of page size.
- R5: After each handshaken descriptor, the virtual and physical addresses both advance by the page size. The page sizes of a sequence add up exactly to the widened length.
- R6: `out_elsz`, `out_endian` and `out_mixed` equal the attributes of the request on every descriptor of its sequence.
- R7: A request whose widened length is zero emits no descriptor, and `done` is high in the cycle after acceptance.
- R8: While `out_valid` is high and `out_ready` is low, the descriptor stays unchanged on the next cycle.
- R9: From the cycle after acceptance until the cycle in which `done` is high, `in_ready` is 0.
- R10: `done` rises in the cycle after the handshake of the last descriptor, and `out_valid` is low while `done` is high.
- R11: When the length remains but no enabled size fits, `cfg_err` and `done` are high together for one cycle and no further descriptor follows.
- R12: A reset during a sequence drops `out_valid`, abandons the sequence, and leaves the block ready to accept a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block idle, request accepted this cycle if offered |
| in_va | input | ADDR_W | Virtual start address |
| in_pa | input | ADDR_W | Physical start address |
| in_size | input | SIZE_W | Region length in bytes |
| in_elsz | input | ELSZ_W | Element-size attribute |
| in_endian | input | 1 | Endianness attribute |
| in_mixed | input | 1 | Mixed-size attribute |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_va | output | ADDR_W | Page virtual address |
| out_pa | output | ADDR_W | Page physical address |
| out_pgsz | output | 2 | Page size code (0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB) |
| out_elsz | output | ELSZ_W | Copied element size |
| out_endian | output | 1 | Copied endianness |
| out_mixed | output | 1 | Copied mixed-size flag |
| done | output | 1 | One-cycle end-of-sequence pulse |
| cfg_err | output | 1 | One-cycle pulse: no page size fits |

## Verification
The configuration error is the hardest case to reach. Under the default build it cannot happen at all, because after widening a 4 KB page always fits. The bench therefore runs a second instance, built without the 4 KB size, on the same request channel. It offers that instance a region that leaves a 4 KB tail after a 64 KB page, which forces one descriptor followed by the error. Back-pressure during a run that mixes 1 MB and 16 MB pages is reached with a fixed out_ready pattern that stalls some descriptors and passes others.

// File: rtl/page_split_pkg.sv
package page_split_pkg;

  localparam int unsigned N_PG    = 4;
  localparam int unsigned PGSZ_W  = 2;
  localparam int unsigned GRAN_SH = 12;

  typedef enum logic [PGSZ_W-1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pgsz_e;

  // log2 of the page size for code idx: 12, 16, 20, 24
  function automatic int unsigned pg_shift(input int unsigned idx);
    return GRAN_SH + 4 * idx;
  endfunction

endpackage

// File: rtl/page_split_norm.sv
module page_split_norm
  import page_split_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SIZE_W = 32,
  parameter int unsigned REM_W  = SIZE_W + 1
) (
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] pa,
  input  logic [SIZE_W-1:0] size,
  output logic [ADDR_W-1:0] va_al,
  output logic [ADDR_W-1:0] pa_al,
  output logic [REM_W-1:0]  len
);

  localparam logic [REM_W-1:0]  GMASK_L = (REM_W'(1) << GRAN_SH) - REM_W'(1);
  localparam logic [ADDR_W-1:0] GMASK_A = (ADDR_W'(1) << GRAN_SH) - ADDR_W'(1);

  logic [REM_W-1:0] widened;

  always_comb begin
    widened = REM_W'(size) + REM_W'(va[GRAN_SH-1:0]);
    len     = (widened + GMASK_L) & ~GMASK_L;
    va_al   = va & ~GMASK_A;
    pa_al   = pa & ~GMASK_A;
  end

endmodule

// File: rtl/page_split_chooser.sv
module page_split_chooser
  import page_split_pkg::*;
#(
  parameter int unsigned   ADDR_W    = 32,
  parameter int unsigned   REM_W     = 33,
  parameter logic [N_PG-1:0] PAGE_MASK = 4'b1111
) (
  input  logic [ADDR_W-1:0] va,
  input  logic [REM_W-1:0]  rem,
  output logic              ok,
  output pgsz_e             code,
  output logic [REM_W-1:0]  bytes
);

  logic [N_PG-1:0]  fits;
  logic [REM_W-1:0] sz_tab [N_PG];

  for (genvar i = 0; i < N_PG; i++) begin : g_size
    localparam int unsigned       SH = pg_shift(i);
    localparam logic [ADDR_W-1:0] AM = (ADDR_W'(1) << SH) - ADDR_W'(1);
    localparam logic [REM_W-1:0]  SZ = REM_W'(1) << SH;
    if (PAGE_MASK[i]) begin : g_on
      assign fits[i] = (rem >= SZ) && ((va & AM) == '0);
    end else begin : g_off
      assign fits[i] = 1'b0;
    end
    assign sz_tab[i] = SZ;
  end

  // ascending scan: the largest qualifying size is written last and wins
  always_comb begin
    ok    = 1'b0;
    code  = PG_4K;
    bytes = '0;
    for (int i = 0; i < N_PG; i++) begin
      if (fits[i]) begin
        ok    = 1'b1;
        code  = pgsz_e'(i);
        bytes = sz_tab[i];
      end
    end
  end

endmodule

// File: rtl/page_splitter.sv
module page_splitter
  import page_split_pkg::*;
#(
  parameter int unsigned     ADDR_W    = 32,
  parameter int unsigned     SIZE_W    = 32,
  parameter int unsigned     ELSZ_W    = 2,
  parameter logic [N_PG-1:0] PAGE_MASK = 4'b1111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_va,
  input  logic [ADDR_W-1:0] in_pa,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [ELSZ_W-1:0] in_elsz,
  input  logic              in_endian,
  input  logic              in_mixed,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_va,
  output logic [ADDR_W-1:0] out_pa,
  output logic [PGSZ_W-1:0] out_pgsz,
  output logic [ELSZ_W-1:0] out_elsz,
  output logic              out_endian,
  output logic              out_mixed,
  output logic              done,
  output logic              cfg_err
);

  localparam int unsigned REM_W = SIZE_W + 1;

  typedef enum logic {ST_IDLE, ST_WALK} st_e;

  st_e               st_q;
  logic [ADDR_W-1:0] cur_va_q, cur_pa_q;
  logic [REM_W-1:0]  rem_q;
  logic [ELSZ_W-1:0] elsz_q;
  logic              endian_q, mixed_q;
  logic              ovalid_q, done_q, err_q;
  logic [ADDR_W-1:0] ova_q, opa_q;
  pgsz_e             ocode_q;

  logic [ADDR_W-1:0] n_va, n_pa;
  logic [REM_W-1:0]  n_len;
  logic              pick_ok;
  pgsz_e             pick_code;
  logic [REM_W-1:0]  pick_bytes;
  logic              accept, step;

  page_split_norm #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .REM_W(REM_W)
  ) u_norm (
    .va(in_va), .pa(in_pa), .size(in_size),
    .va_al(n_va), .pa_al(n_pa), .len(n_len)
  );

  page_split_chooser #(
    .ADDR_W(ADDR_W), .REM_W(REM_W), .PAGE_MASK(PAGE_MASK)
  ) u_pick (
    .va(cur_va_q), .rem(rem_q),
    .ok(pick_ok), .code(pick_code), .bytes(pick_bytes)
  );

  assign accept = (st_q == ST_IDLE) && in_valid;
  // a new step may run when the output slot is empty or being drained
  assign step   = (st_q == ST_WALK) && (!ovalid_q || out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      ovalid_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rem_q    <= '0;
      cur_va_q <= '0;
      cur_pa_q <= '0;
      elsz_q   <= '0;
      endian_q <= 1'b0;
      mixed_q  <= 1'b0;
      ova_q    <= '0;
      opa_q    <= '0;
      ocode_q  <= PG_4K;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        cur_va_q <= n_va;
        cur_pa_q <= n_pa;
        rem_q    <= n_len;
        elsz_q   <= in_elsz;
        endian_q <= in_endian;
        mixed_q  <= in_mixed;
        if (n_len == '0) begin
          done_q <= 1'b1;
        end else begin
          st_q <= ST_WALK;
        end
      end else if (step) begin
        if (rem_q == '0) begin
          ovalid_q <= 1'b0;
          done_q   <= 1'b1;
          st_q     <= ST_IDLE;
        end else if (pick_ok) begin
          ovalid_q <= 1'b1;
          ova_q    <= cur_va_q;
          opa_q    <= cur_pa_q;
          ocode_q  <= pick_code;
          cur_va_q <= cur_va_q + ADDR_W'(pick_bytes);
          cur_pa_q <= cur_pa_q + ADDR_W'(pick_bytes);
          rem_q    <= rem_q - pick_bytes;
        end else begin
          ovalid_q <= 1'b0;
          err_q    <= 1'b1;
          done_q   <= 1'b1;
          st_q     <= ST_IDLE;
        end
      end
    end
  end

  assign in_ready   = (st_q == ST_IDLE);
  assign out_valid  = ovalid_q;
  assign out_va     = ova_q;
  assign out_pa     = opa_q;
  assign out_pgsz   = ocode_q;
  assign out_elsz   = elsz_q;
  assign out_endian = endian_q;
  assign out_mixed  = mixed_q;
  assign done       = done_q;
  assign cfg_err    = err_q;

endmodule

// File: rtl/page_splitter_chk.sv
module page_splitter_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_va,
  input logic [ADDR_W-1:0] out_pa,
  input logic [1:0]        out_pgsz,
  input logic              done,
  input logic              cfg_err
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!out_valid && !done && !cfg_err && in_ready));

  a_r2_granule: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_va[11:0] == 12'd0 && out_pa[11:0] == 12'd0));

  a_r3_va_fits_page: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_va & ((ADDR_W'(1) << (12 + 4 * out_pgsz)) - ADDR_W'(1))) == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_va) && $stable(out_pa) && $stable(out_pgsz)));

  a_r9_busy: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!in_ready || done));

  a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);

  a_r11_err_ends: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> done);

endmodule

bind page_splitter page_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_va(out_va),
  .out_pa(out_pa), .out_pgsz(out_pgsz), .done(done), .cfg_err(cfg_err)
);

// File: tb/page_splitter_bench.sv
`timescale 1ns/1ps
module page_splitter_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_va = '0, in_pa = '0, in_size = '0;
  logic [1:0]  in_elsz = '0;
  logic        in_endian = 1'b0, in_mixed = 1'b0;

  logic        a_ir, a_ov, a_en, a_mx, a_dn, a_er;
  logic [31:0] a_va, a_pa;
  logic [1:0]  a_pg, a_el;
  logic        b_ir, b_ov, b_en, b_mx, b_dn, b_er;
  logic [31:0] b_va, b_pa;
  logic [1:0]  b_pg, b_el;

  page_splitter u_page_splitter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(a_ir),
    .in_va(in_va), .in_pa(in_pa), .in_size(in_size), .in_elsz(in_elsz),
    .in_endian(in_endian), .in_mixed(in_mixed), .out_valid(a_ov),
    .out_ready(out_ready), .out_va(a_va), .out_pa(a_pa), .out_pgsz(a_pg),
    .out_elsz(a_el), .out_endian(a_en), .out_mixed(a_mx), .done(a_dn),
    .cfg_err(a_er)
  );

  // variant without the 4 KB size, the only build where R11 can occur
  page_splitter #(.PAGE_MASK(4'b1110)) u_page_splitter_no4k (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(b_ir),
    .in_va(in_va), .in_pa(in_pa), .in_size(in_size), .in_elsz(in_elsz),
    .in_endian(in_endian), .in_mixed(in_mixed), .out_valid(b_ov),
    .out_ready(out_ready), .out_va(b_va), .out_pa(b_pa), .out_pgsz(b_pg),
    .out_elsz(b_el), .out_endian(b_en), .out_mixed(b_mx), .done(b_dn),
    .cfg_err(b_er)
  );

  logic        sel = 1'b0;
  logic        o_ir, o_ov, o_en, o_mx, o_dn, o_er;
  logic [31:0] o_va, o_pa;
  logic [1:0]  o_pg, o_el;
  always_comb begin
    o_ir = sel ? b_ir : a_ir;  o_ov = sel ? b_ov : a_ov;
    o_va = sel ? b_va : a_va;  o_pa = sel ? b_pa : a_pa;
    o_pg = sel ? b_pg : a_pg;  o_el = sel ? b_el : a_el;
    o_en = sel ? b_en : a_en;  o_mx = sel ? b_mx : a_mx;
    o_dn = sel ? b_dn : a_dn;  o_er = sel ? b_er : a_er;
  end

  int total = 0, fails = 0;
  int cycles = 0;

  task automatic chk(input bit cond, input string tag, input longint act, input longint exp);
    total++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  longint exp_va [64];
  longint exp_pa [64];
  int     exp_pg [64];
  int     exp_n;
  bit     exp_err;

  // reference walk derived from R2, R3, R5, R11
  task automatic model(input longint va, input longint pa, input longint sz, input bit [3:0] mask);
    longint v, p, len;
    v = va & 64'hFFFF_F000;
    p = pa & 64'hFFFF_F000;
    len = ((sz + (va & 64'hFFF)) + 64'hFFF) & ~64'hFFF;
    exp_n = 0; exp_err = 0;
    while (len > 0) begin
      bit found = 0;
      for (int k = 3; k >= 0; k--) begin
        longint ps = 64'd1 << (12 + 4 * k);
        if (!found && mask[k] && len >= ps && (v % ps) == 0) begin
          exp_va[exp_n] = v; exp_pa[exp_n] = p; exp_pg[exp_n] = k;
          exp_n++;
          v = (v + ps) & 64'hFFFF_FFFF;
          p = (p + ps) & 64'hFFFF_FFFF;
          len -= ps;
          found = 1;
        end
      end
      if (!found) begin
        exp_err = 1;
        break;
      end
    end
  endtask

  task automatic run_req(input bit s, input logic [31:0] va, input logic [31:0] pa,
                         input logic [31:0] sz, input logic [1:0] el, input bit en,
                         input bit mx, input logic [7:0] pat, input string name);
    int  idx = 0;
    bit  prev_hs, stalled = 0, fin = 0;
    logic [31:0] sv_va = '0, sv_pa = '0;
    logic [1:0]  sv_pg = '0;
    sel = s;
    model(va, pa, sz, s ? 4'b1110 : 4'b1111);
    @(negedge clk);
    while (!o_ir) @(negedge clk);
    in_va = va; in_pa = pa; in_size = sz; in_elsz = el;
    in_endian = en; in_mixed = mx; in_valid = 1'b1;
    @(posedge clk); #0.5;
    in_valid = 1'b0;
    prev_hs = 1;
    for (int c = 0; c < 2000 && !fin; c++) begin
      @(negedge clk);
      out_ready = pat[c % 8];
      if (o_dn) begin
        chk(prev_hs, {name, " R10 done follows last handshake"}, 0, 1);
        chk(o_ir == 1'b1, {name, " R9 ready with done"}, o_ir, 1);
        chk(o_er == exp_err, {name, " R11 error flag"}, o_er, exp_err);
        chk(idx == exp_n, {name, " R5 page count"}, idx, exp_n);
        fin = 1;
      end else begin
        chk(o_ir == 1'b0, {name, " R9 busy"}, o_ir, 0);
        if (o_ov) begin
          if (stalled) begin
            chk(o_va == sv_va && o_pa == sv_pa && o_pg == sv_pg,
                {name, " R8 held descriptor"}, o_va, sv_va);
          end
          if (out_ready) begin
            if (idx < exp_n) begin
              chk(o_va == exp_va[idx][31:0], {name, " R2 R5 va"}, o_va, exp_va[idx]);
              chk(o_pa == exp_pa[idx][31:0], {name, " R4 pa"}, o_pa, exp_pa[idx]);
              chk(o_pg == 2'(exp_pg[idx]), {name, " R3 size code"}, o_pg, exp_pg[idx]);
              chk(o_el == el && o_en == en && o_mx == mx, {name, " R6 attributes"},
                  {o_el, o_en, o_mx}, {el, en, mx});
            end else begin
              chk(0, {name, " R5 extra page"}, idx, exp_n);
            end
            idx++;
            prev_hs = 1; stalled = 0;
          end else begin
            sv_va = o_va; sv_pa = o_pa; sv_pg = o_pg;
            stalled = 1; prev_hs = 0;
          end
        end else begin
          prev_hs = 0; stalled = 0;
        end
      end
    end
    chk(fin, {name, " R10 sequence ended"}, fin, 1);
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    chk(a_ov == 0 && a_dn == 0 && a_er == 0, "R1 outputs idle in reset", {a_ov, a_dn, a_er}, 0);
    chk(a_ir == 1, "R1 ready in reset", a_ir, 1);
  endtask

  task automatic t_zero;
    run_req(0, 32'h0000_5000, 32'h0000_9000, 32'd0, 2'd1, 1, 0, 8'hFF, "zero R7");
  endtask

  task automatic t_mid_reset;
    sel = 0; out_ready = 1'b0;
    @(negedge clk);
    in_va = 32'h0; in_pa = 32'h0; in_size = 32'h0400_0000; in_valid = 1'b1;
    @(posedge clk); #0.5;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(a_ov == 1, "R12 page pending before reset", a_ov, 1);
    rst = 1'b1;
    @(posedge clk); #0.5;
    rst = 1'b0;
    @(negedge clk);
    chk(a_ov == 0 && a_dn == 0, "R12 sequence dropped", {a_ov, a_dn}, 0);
    chk(a_ir == 1, "R12 ready after reset", a_ir, 1);
    out_ready = 1'b1;
    run_req(0, 32'h0001_0000, 32'h0003_0000, 32'h0001_0000, 2'd0, 0, 0, 8'hFF, "after reset R12");
  endtask

  initial begin
    rst = 1'b1;
    t_reset_state();
    repeat (2) @(posedge clk);
    #0.5 rst = 1'b0;
    // R3: 16M, 16M, 1M
    run_req(0, 32'h0100_0000, 32'h8000_0000, 32'h0210_0000, 2'd2, 1, 1, 8'hFF, "large R3");
    // R2, R4: offset widening, misaligned pa, 4K then two 64K
    run_req(0, 32'h0000_F123, 32'h1234_5678, 32'h0002_0000, 2'd1, 0, 1, 8'hFF, "widen R2");
    // R2: two bytes straddling a 4K boundary become two pages
    run_req(0, 32'h0000_2FFF, 32'h0000_0ABC, 32'd2, 2'd3, 1, 0, 8'hFF, "straddle R2");
    t_zero();
    // R8: stalls across 1M, 16M, 1M
    run_req(0, 32'h00F0_0000, 32'h4000_0000, 32'h0120_0000, 2'd0, 1, 1, 8'b0110_0101, "stall R8");
    // R11: no-4K build, 64K page then no size fits the 4K tail
    run_req(1, 32'h0000_0000, 32'h0000_0000, 32'h0001_1000, 2'd2, 0, 1, 8'hFF, "no4k R11");
    t_mid_reset();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule